// File: doc/BRIEF.md
# Down-Spread Triangular Offset Generator

This block produces the frequency-offset profile that a fractional-N feedback divider uses to spread the spectrum of the clocks derived from the processor PLL. Its output is a signed word in parts per million, and that word never rises above zero. When modulation is on, the word sweeps in a symmetric triangle. Each period starts at zero, falls linearly to a negative peak, and climbs back to zero. A free-running prescaler on the block clock sets the step rate. One full triangle is 2 x `STEPS_HALF` steps of `STEP_DIV` clocks each. With the default settings on a 100 MHz clock this is 3000 clocks, about 33.3 kHz.

Two run-time controls come from the configuration logic. An enable starts and stops the modulation. An amplitude select chooses between the full peak of -5000 ppm (0.5 %) and a reduced peak of -2500 ppm. Turning the enable off never makes the word jump: it climbs back to zero one step at a time and then stays there. The amplitude select is only taken while the word sits at zero, so each triangle is completed with a single slope. A flag reports whether the current half of the sweep is the descending one.

Top module: `downSpreadGen`

## Requirements
- R1: While `rstN` is low, and after its release until the first step, `offsetPpm` is 0 and `dirDown` is 0.
- R2: `offsetPpm` is never above 0 and never below -`PEAK_PPM` (-5000).
- R3: The output moves only on a step edge. Step edges are the `STEP_DIV`-th rising clock edge after reset release and every `STEP_DIV`-th edge after that. A single step changes the value by at most one step size.
- R4: With the enable high and the amplitude select at 0, the sweep leaves zero in steps of -50 ppm and reaches exactly -5000 after 100 steps. It then rises to 0 in +50 ppm steps. A period is 200 steps, which is 3000 clocks by default.
- R5: `dirDown` goes to 1 on the step that leaves zero while enabled, and to 0 on the step that reaches the peak. It only changes on step edges, and it is 1 only while `offsetPpm` is negative.
- R6: While the enable is low, each step raises the offset by one step size, clamped at 0. `dirDown` goes to 0 on the first such step. Once at 0, the offset holds at 0 with `dirDown` at 0 and never falls.
- R7: With the amplitude select at 1 (reduced), the step is 25 ppm and the peak is -2500 ppm. The period is the same 200 steps.
- R8: The amplitude select is captured only on clocks where `offsetPpm` is 0 and no step is taken. A change during a sweep has no effect until the sweep has returned to zero.
- R9: If the enable returns while the offset is climbing back after a disable, the climb continues to 0. The next step from zero starts a new descending half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the step prescaler counts it |
| rstN | input | 1 | Active-low synchronous reset |
| spreadEn | input | 1 | 1 runs the triangular sweep, 0 ramps back to and holds zero |
| ampHalfSel | input | 1 | 0 selects the full peak of -5000 ppm, 1 selects the reduced peak of -2500 ppm |
| offsetPpm | output | OFF_W (16) | Signed frequency offset in ppm, always zero or negative |
| dirDown | output | 1 | 1 while the sweep is in its descending half |

## Verification
Several uninterrupted full-amplitude and reduced-amplitude sweeps starting from zero show that the peak depth, the step size and the 3000-clock spacing of descending halves all follow the amplitude select. A disable in the middle of a descent tells a clean upward ramp apart from a jump or a continued fall. A later idle stretch confirms that zero is held. An amplitude change in the middle of a sweep, and a re-enable during the climb back, tell apart behaviour that waits for zero from behaviour that reacts at once. Random holds of enable and amplitude, with lengths that do not line up with the step grid, are compared clock by clock against a step-level model of the sweep.

// File: rtl/downSpreadPkg.sv
package downSpreadPkg;

  // Strobes from control to datapath for one step edge.
  typedef struct packed {
    logic move;   // apply a step this clock
    logic down;   // 1: subtract, 0: add
    logic half;   // reduced amplitude in force
  } stepCmd_t;

  // Status returned by the datapath about the candidate next values.
  typedef struct packed {
    logic atZero;   // offset is exactly zero now
    logic hitPeak;  // a downward step would reach or pass the peak
    logic hitZero;  // an upward step would reach or pass zero
  } pathFlags_t;

endpackage

// File: rtl/downSpreadCtrl.sv
module downSpreadCtrl
  import downSpreadPkg::*;
#(
  parameter int STEP_DIV = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spreadEn,
  input  logic       ampHalfSel,
  input  pathFlags_t flags,
  output stepCmd_t   cmd,
  output logic       dirDown
);

  localparam int CNT_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_DIV - 1);

  logic [CNT_W-1:0] divCnt;
  logic             stepStb;
  logic             dirQ, dirNext;
  logic             ampHalfQ;
  logic             moveNow, downNow;

  assign stepStb = (divCnt == CNT_LAST);

  // Free-running step prescaler.
  always_ff @(posedge clk) begin
    if (!rstN)        divCnt <= '0;
    else if (stepStb) divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end

  // Decide the step direction for this strobe.
  always_comb begin
    moveNow = 1'b0;
    downNow = 1'b0;
    dirNext = dirQ;
    if (stepStb) begin
      if (flags.atZero) begin
        if (spreadEn) begin
          moveNow = 1'b1;
          downNow = 1'b1;
          dirNext = !flags.hitPeak;
        end else begin
          dirNext = 1'b0;
        end
      end else if (dirQ && spreadEn) begin
        moveNow = 1'b1;
        downNow = 1'b1;
        if (flags.hitPeak) dirNext = 1'b0;
      end else begin
        moveNow = 1'b1;
        downNow = 1'b0;
        dirNext = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ     <= 1'b0;
      ampHalfQ <= 1'b0;
    end else begin
      dirQ <= dirNext;
      if (flags.atZero && !stepStb) ampHalfQ <= ampHalfSel;
    end
  end

  assign cmd.move = moveNow;
  assign cmd.down = downNow;
  assign cmd.half = ampHalfQ;
  assign dirDown  = dirQ;

endmodule

// File: rtl/downSpreadPath.sv
module downSpreadPath
  import downSpreadPkg::*;
#(
  parameter int OFF_W      = 16,
  parameter int PEAK_PPM   = 5000,
  parameter int STEPS_HALF = 100
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  stepCmd_t                cmd,
  output pathFlags_t              flags,
  output logic signed [OFF_W-1:0] offset
);

  localparam int PEAK_RED  = PEAK_PPM / 2;
  localparam int STEP_FULL = PEAK_PPM / STEPS_HALF;
  localparam int STEP_RED  = PEAK_RED / STEPS_HALF;
  localparam logic signed [OFF_W-1:0] STEP_F = OFF_W'(STEP_FULL);
  localparam logic signed [OFF_W-1:0] STEP_R = OFF_W'(STEP_RED);
  localparam logic signed [OFF_W-1:0] NEG_F  = OFF_W'(-PEAK_PPM);
  localparam logic signed [OFF_W-1:0] NEG_R  = OFF_W'(-PEAK_RED);

  logic signed [OFF_W-1:0] offQ, stepMag, peakNeg, downVal, upVal;

  assign stepMag = cmd.half ? STEP_R : STEP_F;
  assign peakNeg = cmd.half ? NEG_R : NEG_F;
  assign downVal = offQ - stepMag;
  assign upVal   = offQ + stepMag;

  always_comb begin
    flags.atZero  = (offQ == '0);
    flags.hitPeak = (downVal <= peakNeg);
    flags.hitZero = !upVal[OFF_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ <= '0;
    end else if (cmd.move) begin
      if (cmd.down) offQ <= flags.hitPeak ? peakNeg : downVal;
      else          offQ <= flags.hitZero ? '0 : upVal;
    end
  end

  assign offset = offQ;

endmodule

// File: rtl/downSpreadGen.sv
module downSpreadGen
  import downSpreadPkg::*;
#(
  parameter int OFF_W      = 16,
  parameter int PEAK_PPM   = 5000,
  parameter int STEPS_HALF = 100,
  parameter int STEP_DIV   = 15
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    spreadEn,
  input  logic                    ampHalfSel,
  output logic signed [OFF_W-1:0] offsetPpm,
  output logic                    dirDown
);

  stepCmd_t   cmd;
  pathFlags_t flags;

  downSpreadCtrl #(.STEP_DIV(STEP_DIV)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .spreadEn   (spreadEn),
    .ampHalfSel (ampHalfSel),
    .flags      (flags),
    .cmd        (cmd),
    .dirDown    (dirDown)
  );

  downSpreadPath #(
    .OFF_W      (OFF_W),
    .PEAK_PPM   (PEAK_PPM),
    .STEPS_HALF (STEPS_HALF)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .flags  (flags),
    .offset (offsetPpm)
  );

endmodule

// File: rtl/downSpreadGen_chk.sv
module downSpreadGen_chk #(
  parameter int OFF_W      = 16,
  parameter int PEAK_PPM   = 5000,
  parameter int STEPS_HALF = 100,
  parameter int STEP_DIV   = 15
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    spreadEn,
  input logic signed [OFF_W-1:0] offsetPpm,
  input logic                    dirDown
);

  localparam int STEP_FULL = PEAK_PPM / STEPS_HALF;

  // Independent step-edge counter kept by the checker.
  int chkCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                       chkCnt <= 0;
    else if (chkCnt == STEP_DIV - 1) chkCnt <= 0;
    else                             chkCnt <= chkCnt + 1;
  end

  assert_never_positive_R2: assert property (@(posedge clk) disable iff (!rstN)
    offsetPpm <= 0);

  assert_above_floor_R2: assert property (@(posedge clk) disable iff (!rstN)
    offsetPpm >= -PEAK_PPM);

  assert_hold_off_grid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (chkCnt != STEP_DIV - 1) |=> $stable(offsetPpm));

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((int'(offsetPpm) - int'($past(offsetPpm))) <= STEP_FULL) &&
    ((int'(offsetPpm) - int'($past(offsetPpm))) >= -STEP_FULL));

  assert_desc_negative_R5: assert property (@(posedge clk) disable iff (!rstN)
    dirDown |-> (offsetPpm < 0));

  assert_disabled_no_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(spreadEn) |-> (offsetPpm >= $past(offsetPpm)));

  assert_disabled_dir_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(spreadEn) && ($past(chkCnt) == STEP_DIV - 1)) |-> !dirDown);

endmodule

bind downSpreadGen downSpreadGen_chk #(
  .OFF_W      (OFF_W),
  .PEAK_PPM   (PEAK_PPM),
  .STEPS_HALF (STEPS_HALF),
  .STEP_DIV   (STEP_DIV)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .spreadEn  (spreadEn),
  .offsetPpm (offsetPpm),
  .dirDown   (dirDown)
);

// File: tb/sim_downSpreadGen.sv
`timescale 1ns/1ps
module sim_downSpreadGen;

  localparam int OFF_W = 16;
  localparam int PEAK  = 5000;
  localparam int HALFN = 100;
  localparam int DIV   = 15;
  localparam int PERIOD_CLKS = 2 * HALFN * DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spreadEn = 1'b0;
  logic ampHalfSel = 1'b0;
  logic signed [OFF_W-1:0] offsetPpm;
  logic dirDown;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int gMin = 0;
  int gMax = 0;

  always #2 clk = ~clk;  // 250 MHz

  downSpreadGen #(.OFF_W(OFF_W), .PEAK_PPM(PEAK), .STEPS_HALF(HALFN), .STEP_DIV(DIV)) u0 (
    .clk(clk), .rstN(rstN), .spreadEn(spreadEn), .ampHalfSel(ampHalfSel),
    .offsetPpm(offsetPpm), .dirDown(dirDown)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int stepOf(input bit half);
    return half ? (PEAK / 2) / HALFN : PEAK / HALFN;
  endfunction

  function automatic int peakOf(input bit half);
    return half ? PEAK / 2 : PEAK;
  endfunction

  // Step-level expected behaviour, derived from the requirements.
  int eCnt = 0;
  int eOff = 0;
  bit eDown = 0;
  bit eHalf = 0;
  bit modelOn = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      eCnt = 0; eOff = 0; eDown = 0; eHalf = 0;
    end else begin
      bit stb;
      int oldOff;
      int st;
      int pk;
      stb = (eCnt == DIV - 1);
      eCnt = stb ? 0 : eCnt + 1;
      oldOff = eOff;
      st = stepOf(eHalf);
      pk = peakOf(eHalf);
      if (stb) begin
        if (eOff == 0) begin
          if (spreadEn) begin
            if (-st <= -pk) begin eOff = -pk; eDown = 0; end
            else begin eOff = -st; eDown = 1; end
          end else eDown = 0;
        end else if (eDown && spreadEn) begin
          if (eOff - st <= -pk) begin eOff = -pk; eDown = 0; end
          else eOff = eOff - st;
        end else begin
          eOff = (eOff + st >= 0) ? 0 : eOff + st;
          eDown = 0;
        end
      end
      if (oldOff == 0 && !stb) eHalf = ampHalfSel;
    end
  end

  // Clock-by-clock comparison against the model (R3 offset timing, R5 flag).
  always @(negedge clk) begin
    if (rstN && modelOn) begin
      check(int'(offsetPpm) == eOff, "R3 offset vs model", int'(offsetPpm), eOff);
      check(dirDown == eDown, "R5 direction flag vs model", int'(dirDown), int'(eDown));
      if (int'(offsetPpm) < gMin) gMin = int'(offsetPpm);
      if (int'(offsetPpm) > gMax) gMax = int'(offsetPpm);
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL R4 watchdog: cycles=%0d expected<=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Observe n cycles: min/max offset, dirDown rises and the last rise spacing,
  // and whether the offset ever fell.
  task automatic observe(input int n, output int mn, output int mx,
                         output int rises, output int spacing, output bit fell);
    int lastRise;
    int prevOff;
    bit prevDir;
    mn = 0; mx = -PEAK - 1; rises = 0; spacing = 0; fell = 0; lastRise = -1;
    prevOff = int'(offsetPpm);
    prevDir = dirDown;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (int'(offsetPpm) < mn) mn = int'(offsetPpm);
      if (int'(offsetPpm) > mx) mx = int'(offsetPpm);
      if (int'(offsetPpm) < prevOff) fell = 1;
      if (dirDown && !prevDir) begin
        if (lastRise >= 0) spacing = i - lastRise;
        lastRise = i;
        rises++;
      end
      prevOff = int'(offsetPpm);
      prevDir = dirDown;
    end
  endtask

  task automatic waitDescBelow(input int lvl, input string tag);
    int n;
    n = 0;
    while (!(dirDown && int'(offsetPpm) <= lvl) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(n < 20000, tag, int'(offsetPpm), lvl);
  endtask

  initial begin
    int mn, mx, rises, spacing;
    bit fell;
    void'($urandom(32'd20240611));

    // Reset state (R1).
    repeat (5) @(negedge clk);
    check(offsetPpm == 0, "R1 offset in reset", int'(offsetPpm), 0);
    check(dirDown == 0, "R1 dirDown in reset", int'(dirDown), 0);
    rstN = 1'b1;
    spreadEn = 1'b1;
    modelOn = 1;
    repeat (DIV - 1) @(negedge clk);
    check(offsetPpm == 0, "R1 offset before first step", int'(offsetPpm), 0);
    @(negedge clk);
    check(int'(offsetPpm) == -50, "R3 first step edge", int'(offsetPpm), -50);
    check(dirDown == 1, "R5 flag on leaving zero", int'(dirDown), 1);

    // Full-amplitude sweep (R4).
    observe(2 * PERIOD_CLKS + 500, mn, mx, rises, spacing, fell);
    check(mn == -PEAK, "R4 full peak depth", mn, -PEAK);
    check(mx == 0, "R4 sweep returns to zero", mx, 0);
    check(spacing == PERIOD_CLKS, "R4 period in clocks", spacing, PERIOD_CLKS);

    // Disable mid-descent: clean ramp back, then hold at zero (R6).
    waitDescBelow(-2000, "R6 reach mid-descent");
    spreadEn = 1'b0;
    observe(1500, mn, mx, rises, spacing, fell);
    check(!fell, "R6 no fall after disable", int'(fell), 0);
    check(offsetPpm == 0, "R6 settled at zero", int'(offsetPpm), 0);
    check(dirDown == 0, "R6 flag cleared", int'(dirDown), 0);
    check(rises == 0, "R6 no new descent", rises, 0);

    // Reduced amplitude (R7).
    ampHalfSel = 1'b1;
    @(negedge clk);
    spreadEn = 1'b1;
    observe(2 * PERIOD_CLKS + 500, mn, mx, rises, spacing, fell);
    check(mn == -PEAK / 2, "R7 reduced peak depth", mn, -PEAK / 2);
    check(spacing == PERIOD_CLKS, "R7 reduced period", spacing, PERIOD_CLKS);

    // Amplitude change inside a full sweep is deferred (R8).
    ampHalfSel = 1'b0;
    waitDescBelow(-2600, "R8 full sweep started");
    ampHalfSel = 1'b1;
    observe(PERIOD_CLKS / 2, mn, mx, rises, spacing, fell);
    check(mn == -PEAK, "R8 sweep keeps full depth", mn, -PEAK);

    // Re-enable during the climb back (R9).
    ampHalfSel = 1'b0;
    waitDescBelow(-3000, "R9 reach descent");
    spreadEn = 1'b0;
    repeat (300) @(negedge clk);
    check(dirDown == 0 && offsetPpm < 0, "R9 climbing before re-enable", int'(offsetPpm), -1);
    spreadEn = 1'b1;
    observe(PERIOD_CLKS, mn, mx, rises, spacing, fell);
    check(mx == 0, "R9 climb reaches zero", mx, 0);
    check(rises >= 1, "R9 new descent after zero", rises, 1);

    // Random holds of enable and amplitude.
    for (int s = 0; s < 40; s++) begin
      spreadEn = ($urandom_range(0, 3) != 0);
      ampHalfSel = $urandom_range(0, 1);
      repeat ($urandom_range(50, 800)) @(negedge clk);
    end

    check(gMin >= -PEAK, "R2 lowest offset", gMin, -PEAK);
    check(gMax <= 0, "R2 highest offset", gMax, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule